// File: doc/BRIEF.md
# RF Battery-Save Power Sequencer

This block duty-cycles the radio front end of a paging receiver. It does this by driving three registered enables: RF power, DC-level restore and PLL. Each enable is placed around the receive window that the decoder expects next. A single-cycle tick marks every bit period, so at 512, 1200 or 2400 bps one lead step lasts about 1.953 ms, 0.833 ms or 0.417 ms.

An external counter reports how many bit periods remain before the window opens. Each enable rises on the tick where that distance equals its own 6-bit lead code. The enables fall when the decoder strobes the end of the window. They also fall 32 bit periods after a break command has been seen in lock mode.

The DC-restore output has two behaviours, chosen by an option bit, and it also depends on the decoder mode. A lead code that is out of range, or a PLL lead that is not strictly longer than the RF lead, latches an error flag. While that flag is set, all three enables are held low until reset.

Top module: `rf_power_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `rf_en`, `pll_en`, `dc_en` and `cfg_err` low at that edge.
- R2: `rf_en` rises at the edge where `bit_tick` is high and `win_dist` equals `rf_lead`. It stays high until `win_end` is sampled high, and is low after that edge.
- R3: `pll_en` follows the same rule with `pll_lead`, and it falls together with `rf_en`. With valid codes and a window approached from above the PLL lead, `rf_en` high implies `pll_en` high.
- R4: `cfg_err` is set at the edge after any of these holds: `rf_lead` is 62 or 63, `pll_lead` is 63, or `pll_lead` <= `rf_lead`. It remains set until reset, and while it is set all three enables are low.
- R5: With `dc_opt`=0 and `mode`=0 (idle), `dc_en` rises with `rf_en` and falls at the tick where `win_dist` is 0, which opens the window. In every other mode `dc_en` stays low.
- R6: With `dc_opt`=1, `dc_en` is high while `rf_en` is high in either of two cases. In lock mode (`mode`=2) it follows `sync_win` one cycle later. In idle mode it runs from the window-open tick until `win_end`. In preamble mode (`mode`=1 or 3) it stays low.
- R7: A `brk_det` pulse sampled in lock mode drops all enables at the 32nd following `bit_tick`. A `brk_det` pulse in any other mode has no effect.
- R8: When `win_end` and a rising tick fall in the same cycle, the clear wins and the enable stays low.
- R9: A `win_dist` equal to a lead code has no effect without `bit_tick`, so enables change only at tick edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| win_dist | input | DW (8) | Bit periods left before the receive window opens |
| rf_lead | input | 6 | RF-enable lead code, in bit periods |
| pll_lead | input | 6 | PLL-enable lead code, in bit periods |
| mode | input | 2 | Decoder state: 0 idle, 1 preamble, 2 lock, 3 treated as preamble |
| dc_opt | input | 1 | Selects the DC-restore behaviour |
| sync_win | input | 1 | High during sync-code receive timing |
| win_end | input | 1 | Strobe marking the end of the receive window |
| brk_det | input | 1 | Break command detected |
| rf_en | output | 1 | RF stage power enable |
| pll_en | output | 1 | PLL enable |
| dc_en | output | 1 | DC-level restore enable |
| cfg_err | output | 1 | Sticky invalid-configuration flag |

## Verification
There are two collisions to cover. The first is a window-end strobe landing in the same cycle as the tick whose distance matches a lead code. The bench provokes this by raising `win_end` during that tick, and the PLL enable must stay low. The second is break expiry landing in the same cycle as ordinary window tracking. The bench counts 31 ticks after the break and checks that the enables are still high, then checks that they are low after the 32nd tick. A behavioural reference model judges every clock for every output, and directed checks cover the points named above.

// File: rtl/rf_power_seq.sv
module rf_power_seq #(
  parameter int DW = 8,
  parameter int CW = 6,
  parameter int BRK_BITS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  logic [DW-1:0] win_dist,
  input  logic [CW-1:0] rf_lead,
  input  logic [CW-1:0] pll_lead,
  input  logic [1:0]    mode,
  input  logic          dc_opt,
  input  logic          sync_win,
  input  logic          win_end,
  input  logic          brk_det,
  output logic          rf_en,
  output logic          pll_en,
  output logic          dc_en,
  output logic          cfg_err
);
  localparam int BW = $clog2(BRK_BITS);
  localparam logic [CW-1:0] CODE_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] RF_LIMIT = CODE_MAX - 1'b1;
  localparam logic [BW-1:0] BRK_LAST = BW'(BRK_BITS - 1);

  logic          in_win, brk_act;
  logic [BW-1:0] brk_cnt;

  wire idle = (mode == 2'd0);
  wire lock = (mode == 2'd2);

  wire bad = (rf_lead >= RF_LIMIT) || (pll_lead == CODE_MAX) || (pll_lead <= rf_lead);
  wire err_n = cfg_err | bad;
  wire brk_done = brk_act & bit_tick & (brk_cnt == BRK_LAST);
  wire stop = win_end | brk_done | err_n;

  wire rf_hit  = bit_tick & (win_dist == DW'(rf_lead));
  wire pll_hit = bit_tick & (win_dist == DW'(pll_lead));
  wire opening = bit_tick & (win_dist == '0) & (rf_en | rf_hit);

  wire rf_n  = ~stop & (rf_en | rf_hit);
  wire pll_n = ~stop & (pll_en | pll_hit);
  wire win_n = ~stop & (in_win | opening);

  logic dc_n;
  always_comb begin
    if (!dc_opt) dc_n = idle & rf_n & ~win_n;
    else         dc_n = rf_n & ((lock & sync_win) | (idle & win_n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_en   <= 1'b0;
      pll_en  <= 1'b0;
      dc_en   <= 1'b0;
      cfg_err <= 1'b0;
      in_win  <= 1'b0;
    end else begin
      rf_en   <= rf_n;
      pll_en  <= pll_n;
      dc_en   <= dc_n;
      cfg_err <= err_n;
      in_win  <= win_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      brk_act <= 1'b0;
      brk_cnt <= '0;
    end else if (!brk_act) begin
      brk_act <= brk_det & lock;
      brk_cnt <= '0;
    end else if (bit_tick) begin
      brk_cnt <= brk_cnt + 1'b1;
    end
  end
endmodule

module rf_power_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_tick,
  input logic [1:0] mode,
  input logic       win_end,
  input logic       rf_en,
  input logic       pll_en,
  input logic       dc_en,
  input logic       cfg_err
);
  assert_err_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!rf_en && !pll_en && !dc_en));
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
  assert_pll_covers_rf_R3: assert property (@(posedge clk) disable iff (rst)
    rf_en |-> pll_en);
  assert_dc_within_rf_R5: assert property (@(posedge clk) disable iff (rst)
    dc_en |-> rf_en);
  assert_end_clears_R2: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (!rf_en && !pll_en));
  assert_rise_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rf_en) |-> $past(bit_tick));
  assert_preamble_dc_low_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'd1) |-> !dc_en);
endmodule

bind rf_power_seq rf_power_seq_chk u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .mode(mode), .win_end(win_end),
  .rf_en(rf_en), .pll_en(pll_en), .dc_en(dc_en), .cfg_err(cfg_err)
);

// File: tb/sim_rf_power_seq.sv
module sim_rf_power_seq;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst = 1, bit_tick = 0, dc_opt = 0, sync_win = 0, win_end = 0, brk_det = 0;
  logic [7:0] win_dist = 8'd200;
  logic [5:0] rf_lead = 6'd4, pll_lead = 6'd8;
  logic [1:0] mode = 2'd0;
  logic rf_en, pll_en, dc_en, cfg_err;

  int checks = 0, errors = 0;
  bit done = 0;

  rf_power_seq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  bit m_rf, m_pll, m_dc, m_err, m_inw;
  int m_left;
  bit b_bad, b_e, b_stop, b_rf, b_pl, b_inw, b_d;

  always @(posedge clk) begin
    if (rst) begin
      m_rf <= 0; m_pll <= 0; m_dc <= 0; m_err <= 0; m_inw <= 0; m_left <= 0;
    end else begin
      b_bad = (rf_lead > 61) || (pll_lead == 63) || (pll_lead <= rf_lead);
      b_e = m_err || b_bad;
      b_stop = win_end || b_e || (m_left == 1 && bit_tick);
      b_rf = !b_stop && (m_rf || (bit_tick && int'(win_dist) == int'(rf_lead)));
      b_pl = !b_stop && (m_pll || (bit_tick && int'(win_dist) == int'(pll_lead)));
      b_inw = !b_stop && (m_inw || (bit_tick && win_dist == 0 && b_rf));
      if (!dc_opt) b_d = (mode == 0) && b_rf && !b_inw;
      else b_d = b_rf && ((mode == 2 && sync_win) || (mode == 0 && b_inw));
      m_rf <= b_rf; m_pll <= b_pl; m_inw <= b_inw; m_dc <= b_d; m_err <= b_e;
      if (b_stop) m_left <= 0;
      else if (m_left == 0 && brk_det && mode == 2) m_left <= 32;
      else if (m_left > 0 && bit_tick) m_left <= m_left - 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk(rf_en == m_rf, "R2 rf_en model", rf_en, m_rf);
    chk(pll_en == m_pll, "R3 pll_en model", pll_en, m_pll);
    chk(dc_en == m_dc, dc_opt ? "R6 dc_en model" : "R5 dc_en model", dc_en, m_dc);
    chk(cfg_err == m_err, "R4 cfg_err model", cfg_err, m_err);
  end

  task automatic tick(int d, bit endw = 0);
    @(negedge clk); win_dist = 8'(d); bit_tick = 1; win_end = endw;
    @(negedge clk); bit_tick = 0; win_end = 0;
  endtask

  task automatic walk(int from, int to);
    for (int d = from; d >= to; d--) tick(d);
  endtask

  task automatic close_win();
    @(negedge clk); win_end = 1; win_dist = 8'd200;
    @(negedge clk); win_end = 0;
    chk(!rf_en && !pll_en && !dc_en, "R2 cleared by win_end", rf_en, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(!rf_en && !pll_en && !dc_en && !cfg_err, "R1 reset state", rf_en, 0);
    rst = 0;

    // idle, option 0
    walk(12, 9);
    chk(!pll_en, "R3 pll before lead", pll_en, 0);
    tick(8);
    chk(pll_en && !rf_en, "R3 pll rises first", pll_en, 1);
    walk(7, 5);
    // R9: matching distance without tick
    @(negedge clk); win_dist = 8'd4;
    @(negedge clk);
    chk(!rf_en, "R9 no tick no rise", rf_en, 0);
    tick(4);
    chk(rf_en && dc_en, "R2 R5 rise together", rf_en, 1);
    walk(3, 1);
    chk(dc_en, "R5 dc held before open", dc_en, 1);
    tick(0);
    chk(rf_en && !dc_en, "R5 dc falls at open", dc_en, 0);
    repeat (3) @(negedge clk);
    chk(rf_en && pll_en, "R2 held in window", rf_en, 1);
    close_win();

    // option 0 in lock: dc low
    mode = 2'd2;
    walk(10, 0);
    chk(rf_en && !dc_en, "R5 lock dc low", dc_en, 0);
    close_win();

    // option 1 idle
    dc_opt = 1; mode = 2'd0;
    walk(10, 1);
    chk(rf_en && !dc_en, "R6 idle dc before open", dc_en, 0);
    tick(0);
    chk(dc_en, "R6 idle dc in window", dc_en, 1);
    close_win();

    // option 1 lock, sync strobe
    mode = 2'd2;
    walk(10, 2);
    @(negedge clk); sync_win = 1;
    @(negedge clk);
    chk(dc_en, "R6 lock sync dc", dc_en, 1);
    sync_win = 0;
    @(negedge clk);
    chk(!dc_en && rf_en, "R6 lock sync ends", dc_en, 0);
    close_win();

    // option 1 preamble
    mode = 2'd1;
    walk(10, 0);
    @(negedge clk); sync_win = 1;
    @(negedge clk); sync_win = 0;
    chk(rf_en && !dc_en, "R6 preamble dc low", dc_en, 0);
    close_win();

    // break in lock
    mode = 2'd2;
    walk(10, 3);
    @(negedge clk); brk_det = 1;
    @(negedge clk); brk_det = 0;
    for (int i = 0; i < 31; i++) tick(200);
    chk(rf_en && pll_en, "R7 held 31 ticks after break", rf_en, 1);
    tick(200);
    chk(!rf_en && !pll_en, "R7 dropped at 32nd tick", rf_en, 0);

    // break in idle ignored
    mode = 2'd0; dc_opt = 0;
    walk(10, 3);
    @(negedge clk); brk_det = 1;
    @(negedge clk); brk_det = 0;
    for (int i = 0; i < 40; i++) tick(200);
    chk(rf_en && pll_en, "R7 idle break ignored", rf_en, 1);
    close_win();

    // collision of win_end and rising tick
    walk(10, 9);
    tick(8, 1);
    chk(!pll_en, "R8 clear wins over rise", pll_en, 0);
    tick(200);

    // error: pll not above rf
    pll_lead = 6'd4;
    @(negedge clk);
    chk(cfg_err, "R4 pll<=rf error", cfg_err, 1);
    pll_lead = 6'd8;
    walk(10, 0);
    chk(cfg_err && !rf_en && !pll_en, "R4 sticky and quiet", cfg_err, 1);
    do_reset();
    chk(!cfg_err, "R1 reset clears error", cfg_err, 0);

    rf_lead = 6'd62; pll_lead = 6'd63;
    @(negedge clk);
    chk(cfg_err, "R4 rf code 62", cfg_err, 1);
    rf_lead = 6'd4; pll_lead = 6'd8;
    do_reset();
    rf_lead = 6'd61; pll_lead = 6'd62;
    @(negedge clk);
    chk(!cfg_err, "R4 largest valid codes", cfg_err, 0);
    walk(64, 61);
    chk(rf_en && pll_en, "R2 long lead rise", rf_en, 1);
    close_win();
    pll_lead = 6'd63;
    @(negedge clk);
    chk(cfg_err, "R4 pll code 63", cfg_err, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule